// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block collects thirteen level-sensitive interrupt request lines from board peripherals. It presents a single 4-bit encoded interrupt level to the processor. Each line maps onto a fixed bit of a 16-bit monitor word. A software-writable enable word gates the monitor word. Among the lines that are both high and enabled, the one with the smallest priority number wins.

The winning priority is inverted bit-wise before it leaves the block. An idle block therefore drives 0, and the most urgent source drives 15. The output is registered. A change on a line, or a write to the enable word, shows on the output after the next rising clock edge.

A small 16-bit register window sits on a plain single-cycle read/write bus. It exposes the enable word, a constant identification register and two general store-and-readback registers. Reads are combinational from the address.

Top module: `irq_level_encoder`

## Requirements
- R1: Monitor bits follow the request lines without latching. When a line drops, its contribution leaves the output at the next edge.
- R2: Request line `src_i[k]` has priority number k. It takes part in arbitration only when the enable word has a set bit at its fixed position. The positions for k = 0..12 are 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15.
- R3: Among the participating lines, the smallest priority number wins.
- R4: `irl_o` equals the winning number XOR 15. With no participant the selected number is 15, so `irl_o` is 0.
- R5: `irl_o` is registered. A line change first shows after the next rising edge and is not visible before that edge.
- R6: A write to the enable word affects `irl_o` at the same edge that stores it. This holds when a line changes in that same cycle.
- R7: The enable word sits at byte offset 0x00. All 16 bits read back. Bits 1, 2 and 3 have no source and never affect `irl_o`.
- R8: The power-off register sits at offset 0x30 and the output-port register at offset 0x36. Each stores a 16-bit write and reads it back.
- R9: The identification register at offset 0x32 always reads 0x0010. Writes to it have no effect.
- R10: Reads of any other offset in the 6-bit window, odd offsets included, return 0. Writes to such offsets change no register.
- R11: After reset, the enable, power-off and output-port registers are 0 and `irl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 13 | Level request lines, bit k has priority number k |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset in the register window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| irl_o | output | 4 | Registered inverted interrupt level |

## Verification
An enable-word write and a request-line transition can land in the same cycle. Both then feed the single output register at one edge. The bench drives a new line pattern and an enable write at the same falling edge. It expects the output after the next rising edge to use the new enable word together with the new lines. It also checks that the output before that edge still shows the old state.

// File: rtl/irq_enc_pkg.sv
`timescale 1ns/1ps
package irq_enc_pkg;
  localparam int NUM_SRC = 13;
  localparam int WORD_W  = 16;
  localparam int LVL_W   = 4;
  localparam logic [LVL_W-1:0] IDLE_LVL = '1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_PWR, SEL_ID, SEL_OPORT
  } sel_e;

  // enable/monitor bit position for the source of priority k
  function automatic int unsigned src_bit(int unsigned k);
    case (k)
      0:       return 11;
      1:       return 9;
      2:       return 8;
      3:       return 12;
      4:       return 10;
      5:       return 6;
      6:       return 5;
      7:       return 4;
      8:       return 7;
      9:       return 14;
      10:      return 13;
      11:      return 0;
      12:      return 15;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_monitor.sv
`timescale 1ns/1ps
module irq_src_monitor
  import irq_enc_pkg::*;
(
  input  logic [NUM_SRC-1:0] src_i,
  output word_t              mon_o
);
  always_comb begin
    mon_o = '0;
    for (int k = 0; k < NUM_SRC; k++) mon_o[src_bit(k)] = src_i[k];
  end
endmodule

// File: rtl/irq_prio_select.sv
`timescale 1ns/1ps
module irq_prio_select
  import irq_enc_pkg::*;
(
  input  word_t mon_i,
  input  word_t mask_i,
  output lvl_t  lvl_o
);
  logic [NUM_SRC-1:0] active;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_act
    localparam int unsigned Pos = src_bit(k);
    assign active[k] = mon_i[Pos] & mask_i[Pos];
  end

  // scan high to low so the smallest active index wins
  always_comb begin
    lvl_o = IDLE_LVL;
    for (int k = NUM_SRC - 1; k >= 0; k--)
      if (active[k]) lvl_o = LVL_W'(k);
  end
endmodule

// File: rtl/irq_reg_window.sv
`timescale 1ns/1ps
module irq_reg_window
  import irq_enc_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] OFS_MASK  = 6'h00,
  parameter logic [ADDR_W-1:0] OFS_PWR   = 6'h30,
  parameter logic [ADDR_W-1:0] OFS_ID    = 6'h32,
  parameter logic [ADDR_W-1:0] OFS_OPORT = 6'h36,
  parameter word_t       ID_VALUE  = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  output word_t             rdata_o,
  output word_t             mask_q_o,
  output word_t             mask_next_o
);
  sel_e  sel;
  word_t mask_q, pwr_q, oport_q;
  logic  wr;

  always_comb begin
    unique case (addr_i)
      OFS_MASK:  sel = SEL_MASK;
      OFS_PWR:   sel = SEL_PWR;
      OFS_ID:    sel = SEL_ID;
      OFS_OPORT: sel = SEL_OPORT;
      default:   sel = SEL_NONE;
    endcase
  end

  assign wr = en_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      pwr_q   <= '0;
      oport_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_MASK:  mask_q  <= wdata_i;
        SEL_PWR:   pwr_q   <= wdata_i;
        SEL_OPORT: oport_q <= wdata_i;
        default:   ;
      endcase
    end
  end

  // lookahead lets a mask write reach the output register at the same edge
  assign mask_next_o = (wr && sel == SEL_MASK) ? wdata_i : mask_q;
  assign mask_q_o    = mask_q;

  always_comb begin
    case (sel)
      SEL_MASK:  rdata_o = mask_q;
      SEL_PWR:   rdata_o = pwr_q;
      SEL_ID:    rdata_o = ID_VALUE;
      SEL_OPORT: rdata_o = oport_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_level_encoder.sv
`timescale 1ns/1ps
module irq_level_encoder
  import irq_enc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  output logic [LVL_W-1:0]   irl_o
);
  word_t mon, mask_q, mask_next;
  lvl_t  lvl, irl_q;

  irq_src_monitor u_mon (
    .src_i (src_i),
    .mon_o (mon)
  );

  irq_reg_window #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (bus_en_i),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .mask_q_o    (mask_q),
    .mask_next_o (mask_next)
  );

  irq_prio_select u_sel (
    .mon_i  (mon),
    .mask_i (mask_next),
    .lvl_o  (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irl_q <= '0;
    else         irl_q <= lvl ^ IDLE_LVL;
  end

  assign irl_o = irl_q;
endmodule

// File: rtl/irq_level_encoder_chk.sv
`timescale 1ns/1ps
module irq_level_encoder_chk
  import irq_enc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               bus_en_i,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [WORD_W-1:0]  bus_wdata_i,
  input logic [WORD_W-1:0]  bus_rdata_o,
  input logic [LVL_W-1:0]   irl_o,
  input logic [WORD_W-1:0]  mask_q,
  input logic [WORD_W-1:0]  mask_next
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i == '0 |=> irl_o == '0); // R4

  AST_TOP_PRIO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i[0] && mask_next[11]) |=> irl_o == 4'hF); // R3

  AST_MASK_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_we_i && bus_addr_i == 6'h00) |=> mask_q == $past(bus_wdata_i)); // R7

  AST_ID_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 6'h32) |-> bus_rdata_o == 16'h0010); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i != 6'h00 && bus_addr_i != 6'h30 && bus_addr_i != 6'h32 &&
     bus_addr_i != 6'h36) |-> bus_rdata_o == '0); // R10
endmodule

bind irq_level_encoder irq_level_encoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irl_o       (irl_o),
  .mask_q      (mask_q),
  .mask_next   (mask_next)
);

// File: tb/irq_level_encoder_bench.sv
`timescale 1ns/1ps
module irq_level_encoder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] src = '0;
  logic        en = 0, we = 0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  irl;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_level_encoder u_irq_level_encoder (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irl_o(irl)
  );

  function automatic int pos_of(int k);
    int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return t[k];
  endfunction

  function automatic logic [3:0] model(logic [12:0] s, logic [15:0] m);
    for (int k = 0; k < 13; k++)
      if (s[k] && m[pos_of(k)]) return 4'(k) ^ 4'hF;
    return 4'h0;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); en = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); en = 0; we = 0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk); en = 1; we = 0; addr = a;
    #1 d = rdata;
    en = 0;
  endtask

  task automatic set_src(logic [12:0] s);
    @(negedge clk); src = s;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R11 irl", 16'(irl), 16'h0);
    bus_rd(6'h00, d); chk("R11 mask", d, 16'h0);
    bus_rd(6'h30, d); chk("R11 pwr", d, 16'h0);
    bus_rd(6'h36, d); chk("R11 oport", d, 16'h0);
    bus_rd(6'h32, d); chk("R9 id", d, 16'h0010);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    bus_wr(6'h30, 16'h1234); bus_wr(6'h36, 16'hBEEF);
    bus_rd(6'h30, d); chk("R8 pwr", d, 16'h1234);
    bus_rd(6'h36, d); chk("R8 oport", d, 16'hBEEF);
    bus_wr(6'h32, 16'hFFFF);
    bus_rd(6'h32, d); chk("R9 id write ignored", d, 16'h0010);
    bus_wr(6'h10, 16'hAAAA); bus_wr(6'h31, 16'h5555);
    bus_rd(6'h10, d); chk("R10 unmapped", d, 16'h0);
    bus_rd(6'h01, d); chk("R10 odd", d, 16'h0);
    bus_rd(6'h30, d); chk("R10 pwr kept", d, 16'h1234);
    bus_rd(6'h36, d); chk("R10 oport kept", d, 16'hBEEF);
    bus_rd(6'h00, d); chk("R10 mask kept", d, 16'h0);
  endtask

  task automatic t_spare_bits;
    logic [15:0] d;
    bus_wr(6'h00, 16'h000E);
    bus_rd(6'h00, d); chk("R7 readback", d, 16'h000E);
    set_src('1);
    chk("R7 spare bits no effect", 16'(irl), 16'h0);
  endtask

  task automatic t_single;
    bus_wr(6'h00, 16'hFFFF);
    for (int k = 0; k < 13; k++) begin
      set_src(13'(1) << k);
      chk($sformatf("R2 R4 single src %0d", k), 16'(irl), 16'(4'(k) ^ 4'hF));
    end
  endtask

  task automatic t_prio;
    logic [15:0] m;
    set_src('1); chk("R3 all", 16'(irl), 16'hF);
    set_src(13'h208); chk("R3 pair 3,9", 16'(irl), 16'(model(13'h208, 16'hFFFF)));
    m = 16'hFFFF & ~(16'h1 << 11);
    bus_wr(6'h00, m);
    set_src(13'h021); chk("R2 masked winner skipped", 16'(irl), 16'(model(13'h021, m)));
    m = 16'h1 << 15;
    bus_wr(6'h00, m);
    set_src('1); chk("R2 only lowest-priority enabled", 16'(irl), 16'h3);
  endtask

  task automatic t_follow;
    bus_wr(6'h00, 16'hFFFF);
    set_src('0); chk("R4 idle", 16'(irl), 16'h0);
    @(negedge clk); src = 13'h080;
    #1 chk("R5 not before edge", 16'(irl), 16'h0);
    @(negedge clk); chk("R5 after edge", 16'(irl), 16'h8);
    src = 13'h0;
    @(negedge clk); chk("R1 drop clears", 16'(irl), 16'h0);
  endtask

  task automatic t_same_cycle;
    src = 13'h002;
    @(negedge clk); chk("R6 setup", 16'(irl), 16'hE);
    // new lines and new mask in one cycle
    src = 13'h005; en = 1; we = 1; addr = 6'h00; wdata = 16'h0100;
    #1 chk("R6 old before edge", 16'(irl), 16'hE);
    @(negedge clk); en = 0; we = 0;
    chk("R6 same edge", 16'(irl), 16'(model(13'h005, 16'h0100)));
    // mask write alone
    en = 1; we = 1; wdata = 16'h0800;
    @(negedge clk); en = 0; we = 0;
    chk("R6 mask only", 16'(irl), 16'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_spare_bits();
    t_single();
    t_prio();
    t_follow();
    t_same_cycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule